// File: doc/BRIEF.md
# Two-Channel Spread-Spectrum Chip Modulator

This block turns two slow data streams, one for the in-phase (I) branch and one for the quadrature (Q) branch, into spread chip streams. A 32-bit phase accumulator sets the chip rate. The increment is f_chip × 2^32 / f_clk, and a chip strobe is produced each time the accumulator wraps. For example, an increment of 0x064DA730 gives about 3.078 Mchip/s. Each branch has its own 32-bit symbol accumulator, so its symbol rate is set independently of the chip rate and of the spreading code length. Symbol boundaries therefore need not line up with code boundaries.

Each branch selects where its data comes from: nothing, an external serial bit stream, an internal 11-stage pseudo-random test sequence, or constant zeros. A branch spreads its held data bit by XOR with its own 11-stage code generator. That generator is loaded from a seed given as an 8-bit low part and a 3-bit high part, steps once per chip, and is reloaded with the seed after every CODE_LEN chips. A global enable parks the whole block in an idle state.

Top module: `dsss_mod`

## Requirements
- R1: While `mod_en` is high, the chip accumulator starts from 0 and adds `chip_inc` on every clock. The clock edge at which an addition carries out of bit 31 is followed, one edge later, by an edge that raises `chip_stb` for exactly one cycle. New chip values appear on `i_chip`/`q_chip` at that same edge.
- R2: With `chip_inc` = 0x80000000, `chip_stb` is high on every other cycle. With any increment below 2^31, `chip_stb` is never high on two consecutive cycles.
- R3: Each active branch runs its own accumulator from its rate input (`i_rate`/`q_rate`). The edge after a carry is a symbol tick, and at that edge a new data bit is captured. The bit is held until the next symbol tick. When a symbol tick and a chip tick act at the same edge, the chip uses the bit held before that edge.
- R4: Source codes are 0 = off, 1 = external, 2 = test sequence, 3 = zeros. With code 1, `*_ext_take` is high during a symbol-tick cycle, and the bit on `*_ext_bit` in that cycle becomes the held data bit.
- R5: The test sequence uses an 11-stage register with stage 10 as the oldest. Its feedback is stage 10 XOR stage 8 (x^11 + x^9 + 1), shifted in at stage 0. It starts at all ones and is never all zeros. On each symbol tick, stage 10 becomes the data bit and the register steps.
- R6: On each chip tick, an active branch outputs its held data bit XOR stage 10 of its code generator.
- R7: The code generator uses the same feedback as the test sequence. It starts at the seed {seed_hi[2:0], seed_lo[7:0]} and steps once per chip tick. The tick that emits the CODE_LEN-th chip reloads the seed.
- R8: A branch with source code 0 outputs chip 0 and never asserts `*_ext_take`. Its code generator is held at the seed, so the first chip after it becomes active uses the seed's stage 10.
- R9: While `mod_en` is low, all accumulators are cleared, code generators are held at their seeds, the test sequences return to all ones, and `chip_stb`, `i_chip`, `q_chip` and both take outputs are 0 from the next edge on.
- R10: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Global modulator enable |
| chip_inc | input | 32 | Chip accumulator increment |
| i_rate | input | 32 | I symbol accumulator increment |
| q_rate | input | 32 | Q symbol accumulator increment |
| i_src | input | 2 | I data source code |
| q_src | input | 2 | Q data source code |
| i_seed_lo | input | 8 | I code seed, low 8 bits |
| i_seed_hi | input | 3 | I code seed, high 3 bits |
| q_seed_lo | input | 8 | Q code seed, low 8 bits |
| q_seed_hi | input | 3 | Q code seed, high 3 bits |
| i_ext_bit | input | 1 | I external data bit |
| q_ext_bit | input | 1 | Q external data bit |
| i_ext_take | output | 1 | I external bit consumed this cycle |
| q_ext_take | output | 1 | Q external bit consumed this cycle |
| chip_stb | output | 1 | New chips valid this cycle |
| i_chip | output | 1 | I spread chip |
| q_chip | output | 1 | Q spread chip |

## Verification
A symbol tick and a chip tick can act at the same clock edge. In that case the chip must use the data bit held before the edge, while the register captures the new bit. The sweep uses rate pairs where the symbol increment is an exact fraction of the chip increment, such as 0x80000000 and 0x40000000, so the two ticks coincide on a regular schedule. It also uses unrelated pairs, where the coincidence drifts. Every chip is compared with a cycle-level arithmetic model of the requirements, so taking the new bit at such an edge shows up as a chip miscompare.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_PRBS = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  localparam int unsigned SR_W = 11;
  localparam logic [SR_W-1:0] PRBS_INIT = '1;

  // x^11 + x^9 + 1 : feedback from stages 10 and 8, shifted in at stage 0
  function automatic logic [SR_W-1:0] sr_step(input logic [SR_W-1:0] s);
    return {s[SR_W-2:0], s[10] ^ s[8]};
  endfunction

endpackage

// File: rtl/dsss_nco.sv
module dsss_nco #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] sum;
  logic             carry;
  logic             tick_q, tick_d;

  always_comb begin
    {carry, sum} = {1'b0, acc_q} + {1'b0, inc};
    if (en) begin
      acc_d  = sum;
      tick_d = carry;
    end else begin
      acc_d  = '0;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !inc[ACC_W-1] && !$past(inc[ACC_W-1])) |=> !tick_q); // R2

endmodule

// File: rtl/dsss_code_gen.sv
module dsss_code_gen
  import dsss_pkg::*;
#(
  parameter int unsigned CODE_LEN = 2047
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            adv,
  input  logic [SR_W-1:0] seed,
  output logic            code_bit
);

  localparam int unsigned CNT_W = (CODE_LEN > 2) ? $clog2(CODE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_LEN - 1);

  logic [SR_W-1:0]  sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (!run) begin
      sr_d  = seed;
      cnt_d = '0;
    end else if (adv) begin
      if (wrap) begin
        sr_d  = seed;
        cnt_d = '0;
      end else begin
        sr_d  = sr_step(sr_q);
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign code_bit = sr_q[SR_W-1];

  AST_CODE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && adv && wrap) |=> (sr_q == $past(seed))); // R7

  AST_SEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sr_q == $past(seed) && cnt_q == '0)); // R8

endmodule

// File: rtl/dsss_chan.sv
module dsss_chan
  import dsss_pkg::*;
#(
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CODE_LEN = 2047
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             chip_tick,
  input  logic [ACC_W-1:0] rate,
  input  logic [1:0]       src,
  input  logic [SR_W-1:0]  seed,
  input  logic             ext_bit,
  output logic             ext_take,
  output logic             chip
);

  src_e            sel;
  logic            run;
  logic            sym_tick;
  logic            code_bit;
  logic            data_q, data_d;
  logic [SR_W-1:0] prbs_q, prbs_d;
  logic            chip_q, chip_d;

  assign sel = src_e'(src);
  assign run = en && (sel != SRC_OFF);

  dsss_nco #(.ACC_W(ACC_W)) u_sym (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .inc  (rate),
    .tick (sym_tick)
  );

  dsss_code_gen #(.CODE_LEN(CODE_LEN)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .adv     (chip_tick),
    .seed    (seed),
    .code_bit(code_bit)
  );

  always_comb begin
    data_d = data_q;
    prbs_d = prbs_q;
    if (!run) begin
      data_d = 1'b0;
      prbs_d = PRBS_INIT;
    end else if (sym_tick) begin
      case (sel)
        SRC_EXT:  data_d = ext_bit;
        SRC_PRBS: begin
          data_d = prbs_q[SR_W-1];
          prbs_d = sr_step(prbs_q);
        end
        default:  data_d = 1'b0;
      endcase
    end
  end

  always_comb begin
    chip_d = chip_q;
    if (!run)           chip_d = 1'b0;
    else if (chip_tick) chip_d = data_q ^ code_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      prbs_q <= PRBS_INIT;
      chip_q <= 1'b0;
    end else begin
      data_q <= data_d;
      prbs_q <= prbs_d;
      chip_q <= chip_d;
    end
  end

  assign ext_take = run && sym_tick && (sel == SRC_EXT);
  assign chip     = chip_q;

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sym_tick) |=> $stable(data_q)); // R3

  AST_EXT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_take |=> (data_q == $past(ext_bit))); // R4

  AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_q != '0); // R5

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !chip_q); // R8

endmodule

// File: rtl/dsss_mod.sv
module dsss_mod
  import dsss_pkg::*;
#(
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CODE_LEN = 2047
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic [ACC_W-1:0] chip_inc,
  input  logic [ACC_W-1:0] i_rate,
  input  logic [ACC_W-1:0] q_rate,
  input  logic [1:0]       i_src,
  input  logic [1:0]       q_src,
  input  logic [7:0]       i_seed_lo,
  input  logic [2:0]       i_seed_hi,
  input  logic [7:0]       q_seed_lo,
  input  logic [2:0]       q_seed_hi,
  input  logic             i_ext_bit,
  input  logic             q_ext_bit,
  output logic             i_ext_take,
  output logic             q_ext_take,
  output logic             chip_stb,
  output logic             i_chip,
  output logic             q_chip
);

  localparam int unsigned N_CH = 2;

  logic                 chip_tick;
  logic                 stb_q, stb_d;
  logic [ACC_W-1:0]     rate_a [N_CH];
  logic [1:0]           src_a  [N_CH];
  logic [SR_W-1:0]      seed_a [N_CH];
  logic [N_CH-1:0]      ext_a;
  logic [N_CH-1:0]      take_a;
  logic [N_CH-1:0]      chip_a;

  assign rate_a[0] = i_rate;
  assign rate_a[1] = q_rate;
  assign src_a[0]  = i_src;
  assign src_a[1]  = q_src;
  assign seed_a[0] = {i_seed_hi, i_seed_lo};
  assign seed_a[1] = {q_seed_hi, q_seed_lo};
  assign ext_a     = {q_ext_bit, i_ext_bit};

  dsss_nco #(.ACC_W(ACC_W)) u_chip_nco (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (mod_en),
    .inc  (chip_inc),
    .tick (chip_tick)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dsss_chan #(.ACC_W(ACC_W), .CODE_LEN(CODE_LEN)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (mod_en),
      .chip_tick(chip_tick),
      .rate     (rate_a[c]),
      .src      (src_a[c]),
      .seed     (seed_a[c]),
      .ext_bit  (ext_a[c]),
      .ext_take (take_a[c]),
      .chip     (chip_a[c])
    );
  end

  always_comb begin
    stb_d = mod_en && chip_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign chip_stb   = stb_q;
  assign i_chip     = chip_a[0];
  assign q_chip     = chip_a[1];
  assign i_ext_take = take_a[0];
  assign q_ext_take = take_a[1];

  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb |-> $past(chip_tick)); // R1

  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (!chip_stb && !i_chip && !q_chip)); // R9

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> (!i_ext_take && !q_ext_take)); // R9

endmodule

// File: tb/sim_dsss_mod.sv
`timescale 1ns/1ps
module sim_dsss_mod;

  localparam int unsigned L = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mod_en;
  logic [31:0] chip_inc, i_rate, q_rate;
  logic [1:0]  i_src, q_src;
  logic [7:0]  i_seed_lo, q_seed_lo;
  logic [2:0]  i_seed_hi, q_seed_hi;
  logic        i_ext_bit, q_ext_bit;
  logic        i_ext_take, q_ext_take, chip_stb, i_chip, q_chip;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic        checking = 1'b0;
  logic [15:0] cyc;

  always #5 clk = ~clk;

  dsss_mod #(.ACC_W(32), .CODE_LEN(L)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .chip_inc(chip_inc),
    .i_rate(i_rate), .q_rate(q_rate), .i_src(i_src), .q_src(q_src),
    .i_seed_lo(i_seed_lo), .i_seed_hi(i_seed_hi),
    .q_seed_lo(q_seed_lo), .q_seed_hi(q_seed_hi),
    .i_ext_bit(i_ext_bit), .q_ext_bit(q_ext_bit),
    .i_ext_take(i_ext_take), .q_ext_take(q_ext_take),
    .chip_stb(chip_stb), .i_chip(i_chip), .q_chip(q_chip)
  );

  // external stream: a pattern of a free cycle counter
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0; else cyc <= cyc + 16'd1;
  assign i_ext_bit = cyc[0] ^ cyc[2] ^ cyc[5];
  assign q_ext_bit = cyc[1] ^ cyc[3] ^ cyc[4];

  // ---------------- reference model ----------------
  logic [31:0] m_acc;
  logic        m_tick, m_stb;
  logic [31:0] m_sacc [2];
  logic        m_stick[2];
  logic        m_data [2];
  logic [10:0] m_prbs [2];
  logic [10:0] m_code [2];
  int          m_cnt  [2];
  logic        m_chip [2];
  logic [32:0] t;

  function automatic logic [10:0] nxt(input logic [10:0] s);
    logic fb;
    fb = s[10] ^ s[8];
    return (s << 1) | 11'(fb);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !mod_en) begin
      m_acc <= 0; m_tick <= 0; m_stb <= 0;
      for (int c = 0; c < 2; c++) begin
        m_sacc[c] <= 0; m_stick[c] <= 0; m_data[c] <= 0; m_prbs[c] <= 11'h7FF;
        m_code[c] <= (c == 0) ? {i_seed_hi, i_seed_lo} : {q_seed_hi, q_seed_lo};
        m_cnt[c] <= 0; m_chip[c] <= 0;
      end
      if (!rst_n) begin m_code[0] <= 0; m_code[1] <= 0; end
    end else begin
      t = {1'b0, m_acc} + {1'b0, chip_inc};
      m_acc <= t[31:0]; m_tick <= t[32]; m_stb <= m_tick;
      for (int c = 0; c < 2; c++) begin
        logic [1:0]  s;
        logic [31:0] r;
        logic [10:0] sd;
        logic        e;
        s  = (c == 0) ? i_src : q_src;
        r  = (c == 0) ? i_rate : q_rate;
        sd = (c == 0) ? {i_seed_hi, i_seed_lo} : {q_seed_hi, q_seed_lo};
        e  = (c == 0) ? i_ext_bit : q_ext_bit;
        if (s == 2'd0) begin
          m_sacc[c] <= 0; m_stick[c] <= 0; m_data[c] <= 0; m_prbs[c] <= 11'h7FF;
          m_code[c] <= sd; m_cnt[c] <= 0; m_chip[c] <= 0;
        end else begin
          t = {1'b0, m_sacc[c]} + {1'b0, r};
          m_sacc[c] <= t[31:0]; m_stick[c] <= t[32];
          if (m_stick[c]) begin
            if (s == 2'd1) m_data[c] <= e;
            else if (s == 2'd2) begin m_data[c] <= m_prbs[c][10]; m_prbs[c] <= nxt(m_prbs[c]); end
            else m_data[c] <= 1'b0;
          end
          if (m_tick) begin
            m_chip[c] <= m_data[c] ^ m_code[c][10];
            if (m_cnt[c] == L - 1) begin m_code[c] <= sd; m_cnt[c] <= 0; end
            else begin m_code[c] <= nxt(m_code[c]); m_cnt[c] <= m_cnt[c] + 1; end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      if (!rst_n) begin
        chk("R10 chip_stb", chip_stb, 1'b0);
        chk("R10 i_chip", i_chip, 1'b0);
        chk("R10 q_chip", q_chip, 1'b0);
        chk("R10 take", i_ext_take | q_ext_take, 1'b0);
      end else begin
        chk(mod_en ? "R1 R2 chip_stb" : "R9 chip_stb", chip_stb, m_stb);
        chk(mod_en ? "R3 R5 R6 R7 R8 i_chip" : "R9 i_chip", i_chip, m_chip[0]);
        chk(mod_en ? "R3 R5 R6 R7 R8 q_chip" : "R9 q_chip", q_chip, m_chip[1]);
        chk("R4 R8 i_ext_take", i_ext_take, mod_en && m_stick[0] && i_src == 2'd1);
        chk("R4 R8 q_ext_take", q_ext_take, mod_en && m_stick[1] && q_src == 2'd1);
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] chip_set [4];
    logic [31:0] irate_set[4];
    logic [31:0] qrate_set[4];
    chip_set[0] = 32'h8000_0000; irate_set[0] = 32'h4000_0000; qrate_set[0] = 32'h2000_0000;
    chip_set[1] = 32'h7FFF_FFFF; irate_set[1] = 32'h1555_5555; qrate_set[1] = 32'h3FFF_FFFF;
    chip_set[2] = 32'h326D_3980; irate_set[2] = 32'h0A3D_70A4; qrate_set[2] = 32'h1936_9CC0;
    chip_set[3] = 32'hC000_0000; irate_set[3] = 32'h6000_0000; qrate_set[3] = 32'h2345_6789;
    rst_n = 1'b0; mod_en = 1'b0; chip_inc = '0; i_rate = '0; q_rate = '0;
    i_src = 2'd0; q_src = 2'd0;
    i_seed_lo = 8'h01; i_seed_hi = 3'h0; q_seed_lo = 8'hA5; q_seed_hi = 3'h5;
    checking = 1'b1;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 16; k++) begin
        @(posedge clk); #2;
        mod_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chip_inc = chip_set[r]; i_rate = irate_set[r]; q_rate = qrate_set[r];
        i_src = 2'(k % 4); q_src = 2'(k / 4);
        {i_seed_hi, i_seed_lo} = 11'((k * 16'h2B5 + r * 16'h13 + 1) & 16'h7FF);
        {q_seed_hi, q_seed_lo} = 11'((k * 16'h1CB + r * 16'h71 + 3) & 16'h7FF);
        mod_en = 1'b1;
        repeat (110) @(posedge clk);
      end
    end
    @(posedge clk); #2;
    mod_en = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    checking = 1'b0;
    summary();
  end

endmodule